// File: doc/BRIEF.md
# I2C Target General-Call Command Handler

This block is the bus front end of a data-converter-style peripheral that sits as a target on an I2C bus. It samples SCL and SDA with its own system clock, cleans both lines through a synchroniser and a one-sample deglitch, and detects START, STOP and SCL edges. From these it shifts in the first byte after each START and the byte that follows it.

When the first byte is the all-zero general-call address, the block acknowledges it and then acknowledges and decodes the next byte. That byte becomes one of three single-cycle action pulses for the converter core: a full soft reset together with a re-latch of the address-select pins, a re-latch on its own, or the start of one single-shot conversion. Any other byte value in that position is acknowledged and has no effect. A first byte of the form 00001xxx marks a high-speed master code. The block leaves it unacknowledged and raises a high-speed-mode flag, which stays high until the next STOP.

The converter core connects the action pulses to its reset, pin-latch and conversion-trigger logic. The pull-low output drives an open-drain SDA pad.

Top module: `i2c_gencall_target`

## Requirements
- R1: While reset is asserted and after it is released, with the bus idle, the pull-low, soft-reset, latch, conversion-start and high-speed outputs are all 0.
- R2: A first byte of 0x00 after START is acknowledged: the pull-low output is 1 while SCL is high during the ninth clock pulse of that byte.
- R3: The acknowledge is released on the falling SCL edge that ends the ninth pulse, so the pull-low output is 0 during the next data bit.
- R4: A general-call second byte of 0x06 yields a soft-reset pulse and a latch pulse in the same system-clock cycle, with no conversion-start pulse, after the acknowledge of that byte.
- R5: A general-call second byte of 0x04 yields a latch pulse only. Soft reset and conversion start stay 0.
- R6: A general-call second byte of 0x08 yields a conversion-start pulse only. Soft reset and latch stay 0.
- R7: Any other general-call second byte, including 0x00, is acknowledged and produces no action pulse.
- R8: A first byte whose upper five bits are 00001 is not acknowledged, and it sets the high-speed output to 1.
- R9: The high-speed output stays 1 through a repeated START and clears on the next STOP.
- R10: A repeated START inside a byte discards the partial byte, and reception restarts at the first bit of a new first byte.
- R11: A first byte that is neither 0x00 nor 00001xxx is not acknowledged, and the bytes that follow it produce no action pulse.
- R12: Each action pulse lasts exactly one system-clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge) |
| soft_rst_o | output | 1 | One-cycle reset request for the converter core |
| addr_latch_o | output | 1 | One-cycle strobe to latch the address-select pins |
| conv_start_o | output | 1 | One-cycle single-shot conversion trigger |
| hs_mode_o | output | 1 | High-speed master code seen since the last STOP |

## Verification
The bench checks that the reset command raises both soft-reset and latch in one cycle. A decoder that treated 0x06 as reset only would leave the pins unlatched. A second byte of 0x00 and an arbitrary byte such as 0x55 must both be acknowledged with no pulse, which exposes a decoder with a catch-all default. The bench sends a foreign address followed by 0x08 to catch a block that keeps decoding after it has lost interest in the transfer. A high-speed code followed by a repeated START shows whether the flag wrongly clears on START, and a partial byte cut by a repeated START shows whether stale bits or a stale bit count leak into the next address.

// File: rtl/gc_pkg.sv
package gc_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [7:0] GC_ADDR      = 8'h00;
  localparam logic [7:0] CMD_RESET    = 8'h06;
  localparam logic [7:0] CMD_LATCH    = 8'h04;
  localparam logic [7:0] CMD_ONESHOT  = 8'h08;
  localparam logic [4:0] HS_PREFIX    = 5'b00001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_SKIP
  } gc_state_e;

  typedef struct packed {
    logic soft_rst;
    logic latch;
    logic conv;
  } gc_action_t;
endpackage

// File: rtl/gc_rst_sync.sv
module gc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/gc_line_filter.sv
module gc_line_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        IDLE_VAL    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   hold_q, hold_d;
  logic                   out_q, out_d;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], line_i};
    hold_d = synced;
    // accept a new level only after two equal synchronised samples
    out_d  = (synced == hold_q) ? hold_q : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {SYNC_STAGES{IDLE_VAL}};
      hold_q <= IDLE_VAL;
      out_q  <= IDLE_VAL;
    end else begin
      sync_q <= sync_d;
      hold_q <= hold_d;
      out_q  <= out_d;
    end
  end

  assign line_o = out_q;
endmodule

// File: rtl/gc_bus_cond.sv
module gc_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_prev_q, sda_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_f;
      sda_prev_q <= sda_f;
    end
  end

  always_comb begin
    start_o    = scl_f & scl_prev_q & sda_prev_q & ~sda_f;
    stop_o     = scl_f & scl_prev_q & ~sda_prev_q & sda_f;
    scl_rise_o = scl_f & ~scl_prev_q;
    scl_fall_o = ~scl_f & scl_prev_q;
  end
endmodule

// File: rtl/gc_cmd_fsm.sv
module gc_cmd_fsm
  import gc_pkg::*;
#(
  parameter int unsigned BITS = BYTE_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       sda_i,
  output logic       pull_o,
  output gc_action_t act_o,
  output logic       hs_o
);
  localparam int unsigned CNT_W = $clog2(BITS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BITS);

  gc_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BITS-1:0]  shift_q, shift_d;
  logic             pull_q, pull_d;
  logic             hs_q, hs_d;
  gc_action_t       act_q, act_d;
  logic             byte_done;

  assign byte_done = scl_fall_i && (cnt_q == FULL);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shift_d = shift_q;
    pull_d  = pull_q;
    hs_d    = hs_q;
    act_d   = '0;
    if (stop_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      pull_d  = 1'b0;
      hs_d    = 1'b0;
    end else if (start_i) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_CMD: begin
          if (scl_rise_i && (cnt_q != FULL)) begin
            shift_d = {shift_q[BITS-2:0], sda_i};
            cnt_d   = cnt_q + 1'b1;
          end else if (byte_done) begin
            cnt_d = '0;
            if (state_q == ST_CMD) begin
              pull_d  = 1'b1;
              state_d = ST_CMD_ACK;
            end else if (shift_q == GC_ADDR) begin
              pull_d  = 1'b1;
              state_d = ST_ADDR_ACK;
            end else if (shift_q[BITS-1:BITS-5] == HS_PREFIX) begin
              hs_d    = 1'b1;
              state_d = ST_SKIP;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            pull_d  = 1'b0;
            state_d = ST_CMD;
          end
        end
        ST_CMD_ACK: begin
          if (scl_fall_i) begin
            pull_d  = 1'b0;
            state_d = ST_SKIP;
            case (shift_q)
              CMD_RESET: begin
                act_d.soft_rst = 1'b1;
                act_d.latch    = 1'b1;
              end
              CMD_LATCH:   act_d.latch = 1'b1;
              CMD_ONESHOT: act_d.conv  = 1'b1;
              default:     act_d       = '0;
            endcase
          end
        end
        default: begin
          state_d = state_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      pull_q  <= 1'b0;
      hs_q    <= 1'b0;
      act_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      pull_q  <= pull_d;
      hs_q    <= hs_d;
      act_q   <= act_d;
    end
  end

  assign pull_o = pull_q;
  assign act_o  = act_q;
  assign hs_o   = hs_q;

  AST_RST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n) act_q.soft_rst |=> !act_q.soft_rst); // R12
  AST_LATCH_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n) act_q.latch |=> !act_q.latch); // R12
  AST_CONV_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n) act_q.conv |=> !act_q.conv); // R12
  AST_RST_WITH_LATCH: assert property (@(posedge clk) disable iff (!rst_n) act_q.soft_rst |-> act_q.latch); // R4
  AST_CONV_ALONE: assert property (@(posedge clk) disable iff (!rst_n) act_q.conv |-> !act_q.latch); // R6
  AST_HS_CLEAR_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n) stop_i |=> !hs_q); // R9
  AST_ACK_DROP_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) (pull_q && scl_fall_i) |=> !pull_q); // R3
  AST_NO_PULL_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_IDLE) |-> !pull_q); // R11
endmodule

// File: rtl/i2c_gencall_target.sv
module i2c_gencall_target
  import gc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o,
  output logic soft_rst_o,
  output logic addr_latch_o,
  output logic conv_start_o,
  output logic hs_mode_o
);
  localparam int unsigned LINES = 2;

  logic             rst_n_s;
  logic [LINES-1:0] raw_lines;
  logic [LINES-1:0] clean_lines;
  logic             start_w, stop_w, rise_w, fall_w;
  gc_action_t       act_w;

  gc_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_filter
    gc_line_filter #(.SYNC_STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .line_i (raw_lines[g]),
      .line_o (clean_lines[g])
    );
  end

  gc_bus_cond u_cond (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .scl_f      (clean_lines[1]),
    .sda_f      (clean_lines[0]),
    .start_o    (start_w),
    .stop_o     (stop_w),
    .scl_rise_o (rise_w),
    .scl_fall_o (fall_w)
  );

  gc_cmd_fsm #(.BITS(BYTE_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start_i    (start_w),
    .stop_i     (stop_w),
    .scl_rise_i (rise_w),
    .scl_fall_i (fall_w),
    .sda_i      (clean_lines[0]),
    .pull_o     (sda_pull_o),
    .act_o      (act_w),
    .hs_o       (hs_mode_o)
  );

  assign soft_rst_o   = act_w.soft_rst;
  assign addr_latch_o = act_w.latch;
  assign conv_start_o = act_w.conv;
endmodule

// File: tb/i2c_gencall_target_tb.sv
module i2c_gencall_target_tb;
  localparam int Q = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_drv = 1'b1;
  logic sda_line;
  logic sda_pull, soft_rst, addr_latch, conv_start, hs_mode;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [2:0] exp_q[$];
  logic [2:0] prev_act = 3'b000;

  always #10 clk = ~clk;

  assign sda_line = sda_drv & ~sda_pull;

  i2c_gencall_target u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl),
    .sda_i        (sda_line),
    .sda_pull_o   (sda_pull),
    .soft_rst_o   (soft_rst),
    .addr_latch_o (addr_latch),
    .conv_start_o (conv_start),
    .hs_mode_o    (hs_mode)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic do_start();
    sda_drv = 1'b1; wq(); scl = 1'b1; wq();
    sda_drv = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic do_stop();
    sda_drv = 1'b0; wq(); scl = 1'b1; wq(); sda_drv = 1'b1; wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_drv = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked, output logic pull_after);
    send_bits(b, 8);
    sda_drv = 1'b1; wq(); scl = 1'b1; wq();
    acked = ~sda_line;
    wq(); scl = 1'b0; wq();
    pull_after = sda_pull;
  endtask

  // scoreboard monitor: compares each action pulse with the queued expectation
  always @(negedge clk) begin
    logic [2:0] cur;
    cur = {soft_rst, addr_latch, conv_start};
    if (rst_n && prev_act != 3'b000) chk("R12 pulse width", {5'b0, cur}, 8'h00);
    if (rst_n && cur != 3'b000) begin
      if (exp_q.size() == 0) chk("R7/R11 unexpected action", {5'b0, cur}, 8'h00);
      else chk("R4/R5/R6 action", {5'b0, cur}, {5'b0, exp_q.pop_front()});
    end
    prev_act = cur;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic a, p;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {3'b0, sda_pull, soft_rst, addr_latch, conv_start, hs_mode}, 8'h00);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 idle outputs", {3'b0, sda_pull, soft_rst, addr_latch, conv_start, hs_mode}, 8'h00);

    // reset command
    do_start();
    send_byte(8'h00, a, p);
    chk("R2 gc addr ack", {7'b0, a}, 8'h01);
    chk("R3 ack released", {7'b0, p}, 8'h00);
    exp_q.push_back(3'b110);
    send_byte(8'h06, a, p);
    chk("R4 cmd ack", {7'b0, a}, 8'h01);
    do_stop();
    chk("R4 reset+latch issued", 8'(exp_q.size()), 8'h00);

    // latch only
    do_start();
    send_byte(8'h00, a, p);
    exp_q.push_back(3'b010);
    send_byte(8'h04, a, p);
    do_stop();
    chk("R5 latch issued", 8'(exp_q.size()), 8'h00);

    // one-shot conversion
    do_start();
    send_byte(8'h00, a, p);
    exp_q.push_back(3'b001);
    send_byte(8'h08, a, p);
    chk("R3 cmd ack released", {7'b0, p}, 8'h00);
    do_stop();
    chk("R6 conv issued", 8'(exp_q.size()), 8'h00);

    // unsupported second bytes
    do_start();
    send_byte(8'h00, a, p);
    send_byte(8'h00, a, p);
    chk("R7 second byte 00 acked", {7'b0, a}, 8'h01);
    do_stop();
    do_start();
    send_byte(8'h00, a, p);
    send_byte(8'h55, a, p);
    chk("R7 second byte 55 acked", {7'b0, a}, 8'h01);
    do_stop();

    // foreign address
    do_start();
    send_byte(8'h90, a, p);
    chk("R11 foreign addr nack", {7'b0, a}, 8'h00);
    send_byte(8'h08, a, p);
    chk("R11 following byte nack", {7'b0, a}, 8'h00);
    do_stop();

    // high-speed master code
    do_start();
    send_byte(8'h09, a, p);
    chk("R8 hs code nack", {7'b0, a}, 8'h00);
    chk("R8 hs flag set", {7'b0, hs_mode}, 8'h01);
    do_start();
    chk("R9 hs kept over restart", {7'b0, hs_mode}, 8'h01);
    send_byte(8'h00, a, p);
    exp_q.push_back(3'b001);
    send_byte(8'h08, a, p);
    chk("R9 hs still set", {7'b0, hs_mode}, 8'h01);
    do_stop();
    chk("R9 hs cleared by stop", {7'b0, hs_mode}, 8'h00);

    // repeated START inside a byte
    do_start();
    send_bits(8'hF0, 4);
    scl = 1'b0; sda_drv = 1'b1; wq();
    do_start();
    send_byte(8'h00, a, p);
    chk("R10 addr after restart acked", {7'b0, a}, 8'h01);
    exp_q.push_back(3'b010);
    send_byte(8'h04, a, p);
    do_stop();
    chk("R10 latch after restart", 8'(exp_q.size()), 8'h00);

    repeat (20) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule